// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block sits behind a pair of adjacent byte-wide I/O ports and turns them into an indexed configuration space. The even address of the pair is the index port, and the odd address is the data port. The pair sits at one of two base addresses, and a strap input chooses which one. After reset the space is hidden. Software must write an entry key byte to the index port twice in a row to open it. A separate exit key closes it again.

Once the space is open, an index-port write selects a register. Data-port accesses then reach that register. Low indices are answered locally: a logical-device selector plus fixed identification bytes (a device code, a revision and a vendor code). Every index from the forwarding threshold upward goes out on a downstream register bus. Each access on that bus carries the current logical-device number, so the downstream register files can decode which device it is for. Host reads return their byte on `host_rdata` one clock after the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: The port pair occupies addresses 0x2E/0x2F when `strap_alt` is 0 and 0x4E/0x4F when it is 1. Address bit 0 equal to 0 selects the index port and 1 selects the data port. Writes to any other address have no effect, and reads of any other address return 0xFF.
- R2: After reset the block is locked, the index is 0x00, the logical-device number is 0x00 and `host_rdata` is 0xFF.
- R3: Two index-port writes of 0x87 in consecutive index writes open the configuration space.
- R4: An index-port write of any value other than 0x87, arriving after a single 0x87, cancels the partial key and leaves the block locked.
- R5: While the space is open, an index-port write of 0xAA locks it and leaves the stored index unchanged. Any other index-port write loads the index.
- R6: While locked, or while half-way through the key, reads of either port return 0xFF. Data writes have no effect, and the downstream bus sees no strobe.
- R7: While the space is open, a read of the index port returns the stored index.
- R8: Local index 0x20 reads DEV_ID[15:8], 0x21 reads DEV_ID[7:0], 0x22 reads DEV_REV, 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these indices have no effect.
- R9: Index 0x07 holds the logical-device number. It can be read and written, and its value survives a lock/unlock cycle.
- R10: Any other local index below 0x30 reads 0x00, and writes to it have no effect.
- R11: When the space is open and the index is 0x30 or above, a data-port write pulses `dev_wr` and a data-port read pulses `dev_rd`, in the same cycle as the host strobe. `dev_idx`, `dev_ldn` and `dev_wdata` carry the index, the logical-device number and the write byte. `dev_rdata` is taken as the read result.
- R12: `host_rdata` changes only on the clock edge that ends a cycle with `host_rd` high and `host_wr` low, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base select: 0 for 0x2E, 1 for 0x4E |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| dev_wr | output | 1 | Downstream write strobe |
| dev_rd | output | 1 | Downstream read strobe |
| dev_ldn | output | 8 | Selected logical-device number |
| dev_idx | output | 8 | Current register index |
| dev_wdata | output | 8 | Downstream write byte |
| dev_rdata | input | 8 | Downstream read byte, valid in the cycle of `dev_rd` |

## Verification
The properties assume that the host never raises `host_wr` and `host_rd` in the same cycle. They also assume that `dev_rdata` settles in the cycle of `dev_rd`, and that `strap_alt` stays constant during an access. The stimulus keeps every cycle to a single write, a single read or an idle cycle. It drives the downstream read byte from a fixed function of the index and device number, and it changes the strap only between accesses. The key sequencing is exercised with directed partial keys, with exit keys issued while locked, and with a long pseudo-random mix of key bytes, index writes and data accesses at both the claimed and the foreign base.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;

  // Host access after address decode.
  typedef struct packed {
    logic hit;
    logic wr;
    logic rd;
    logic is_data;
  } port_op_t;

  localparam logic [7:0]  KEY_ENTER    = 8'h87;
  localparam logic [7:0]  KEY_EXIT     = 8'hAA;
  localparam logic [7:0]  IDX_LDN      = 8'h07;
  localparam logic [7:0]  IDX_DEVID_HI = 8'h20;
  localparam logic [7:0]  IDX_DEVID_LO = 8'h21;
  localparam logic [7:0]  IDX_REV      = 8'h22;
  localparam logic [7:0]  IDX_MFG_HI   = 8'h23;
  localparam logic [7:0]  IDX_MFG_LO   = 8'h24;
  localparam logic [15:0] MFG_CODE     = 16'h1934;
  localparam logic [7:0]  RD_IDLE      = 8'hFF;

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 'h4E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  output port_op_t          op
);
  localparam int TAG_W = ADDR_W - 1;

  logic [TAG_W-1:0] base_tag;
  logic             match;

  always_comb begin
    base_tag = strap_alt ? BASE_ALT[ADDR_W-1:1] : BASE_PRI[ADDR_W-1:1];
    match    = (host_addr[ADDR_W-1:1] == base_tag);
    op.hit     = match;
    op.wr      = match & host_wr;
    op.rd      = match & host_rd & ~host_wr;
    op.is_data = host_addr[0];
  end
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       index_load
);
  lock_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        LK_LOCKED: if (wdata == KEY_ENTER) state_d = LK_HALF;
        LK_HALF:   state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_LOCKED;
        LK_OPEN:   if (wdata == KEY_EXIT) state_d = LK_LOCKED;
        default:   state_d = LK_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_LOCKED;
    else        state_q <= state_d;
  end

  always_comb begin
    cfg_open   = (state_q == LK_OPEN);
    index_load = idx_wr & cfg_open & (wdata != KEY_EXIT);
  end
endmodule

// File: rtl/sio_local_regs.sv
module sio_local_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'hB7C2,
  parameter logic [7:0]  DEV_REV = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] index,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rdata
);
  logic ldn_we;

  assign ldn_we = wr_en & (index == IDX_LDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ldn <= '0;
    else if (ldn_we) ldn <= wdata;
  end

  always_comb begin
    unique case (index)
      IDX_LDN:      rdata = ldn;
      IDX_DEVID_HI: rdata = DEV_ID[15:8];
      IDX_DEVID_LO: rdata = DEV_ID[7:0];
      IDX_REV:      rdata = DEV_REV;
      IDX_MFG_HI:   rdata = MFG_CODE[15:8];
      IDX_MFG_LO:   rdata = MFG_CODE[7:0];
      default:      rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI  = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 'h4E,
  parameter logic [15:0]       DEV_ID    = 16'hB7C2,
  parameter logic [7:0]        DEV_REV   = 8'h05,
  parameter logic [7:0]        FWD_START = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_ldn,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);
  port_op_t   op;
  logic       cfg_open;
  logic       index_load;
  logic [7:0] idx_q;
  logic [7:0] ldn;
  logic [7:0] local_rdata;
  logic       fwd_win;
  logic       local_wr;
  logic       rd_cycle;
  logic [7:0] rdata_d;

  sio_port_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_PRI(BASE_PRI),
    .BASE_ALT(BASE_ALT)
  ) decode_i (
    .strap_alt(strap_alt),
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .op       (op)
  );

  sio_key_fsm key_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (op.wr & ~op.is_data),
    .wdata     (host_wdata),
    .cfg_open  (cfg_open),
    .index_load(index_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (index_load) idx_q <= host_wdata;
  end

  always_comb begin
    fwd_win  = cfg_open & op.is_data & (idx_q >= FWD_START);
    local_wr = op.wr & op.is_data & cfg_open & (idx_q < FWD_START);
  end

  sio_local_regs #(
    .DEV_ID (DEV_ID),
    .DEV_REV(DEV_REV)
  ) regs_i (
    .clk  (clk),
    .rst_n(rst_n),
    .index(idx_q),
    .wr_en(local_wr),
    .wdata(host_wdata),
    .ldn  (ldn),
    .rdata(local_rdata)
  );

  always_comb begin
    dev_wr    = op.wr & fwd_win;
    dev_rd    = op.rd & fwd_win;
    dev_ldn   = ldn;
    dev_idx   = idx_q;
    dev_wdata = host_wdata;
  end

  always_comb begin
    rd_cycle = host_rd & ~host_wr;
    if (!(op.hit && cfg_open)) rdata_d = RD_IDLE;
    else if (!op.is_data)      rdata_d = idx_q;
    else if (fwd_win)          rdata_d = dev_rdata;
    else                       rdata_d = local_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        host_rdata <= RD_IDLE;
    else if (rd_cycle) host_rdata <= rdata_d;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [7:0] FWD_START = 8'h30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       dev_wr,
  input logic       dev_rd,
  input logic [7:0] dev_idx,
  input logic       cfg_open
);
  // R3: opening is always preceded by an entry key write
  assert_open_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(host_wr && host_wdata == 8'h87));

  // R5: closing is always preceded by an exit key write
  assert_close_after_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(host_wr && host_wdata == 8'hAA));

  // R6: no downstream traffic while closed
  assert_no_fwd_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> !(dev_wr || dev_rd));

  // R6: reads while closed return the idle byte
  assert_idle_read_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && host_rd && !host_wr) |=> host_rdata == 8'hFF);

  // R11: forwarding only in the upper window, one strobe at a time
  assert_fwd_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> dev_idx >= FWD_START);

  assert_fwd_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_wr, dev_rd}));

  // R12: read byte holds without a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> $stable(host_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.FWD_START(FWD_START)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .dev_wr    (dev_wr),
  .dev_rd    (dev_rd),
  .dev_idx   (dev_idx),
  .cfg_open  (cfg_open)
);

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;
  localparam logic [15:0] T_DEV_ID  = 16'hB7C2;
  localparam logic [7:0]  T_DEV_REV = 8'h05;

  logic        clk;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        dev_wr;
  logic        dev_rd;
  logic [7:0]  dev_ldn;
  logic [7:0]  dev_idx;
  logic [7:0]  dev_wdata;
  logic [7:0]  dev_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state: 0 locked, 1 half key, 2 open
  int         m_st;
  logic [7:0] m_idx;
  logic [7:0] m_ldn;
  logic [7:0] m_rdata;
  logic [15:0] lfsr;

  initial clk = 0;
  always #4 clk = ~clk;

  // downstream register file stand-in
  function automatic logic [7:0] devfn(logic [7:0] i, logic [7:0] l);
    return i ^ {l[3:0], l[7:4]} ^ 8'h3C;
  endfunction
  assign dev_rdata = devfn(dev_idx, dev_ldn);

  sio_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_ldn(dev_ldn), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] local_rd(logic [7:0] i, logic [7:0] l);
    if (i >= 8'h30) return devfn(i, l);
    case (i)
      8'h07:   return l;
      8'h20:   return T_DEV_ID[15:8];
      8'h21:   return T_DEV_ID[7:0];
      8'h22:   return T_DEV_REV;
      8'h23:   return 8'h19;
      8'h24:   return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check strobes, advance model, check read byte
  task automatic step(input bit wr, input bit rd, input logic [15:0] a,
                      input logic [7:0] d, input string tag);
    bit hit, fwd, ew, er;
    logic [15:0] base;
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    #1;
    base = strap_alt ? 16'h004E : 16'h002E;
    hit  = (a[15:1] == base[15:1]);
    fwd  = hit && a[0] && (m_st == 2) && (m_idx >= 8'h30);
    ew   = wr && fwd;
    er   = rd && !wr && fwd;
    vectors++;
    cmp(tag, "dev_wr", {7'd0, dev_wr}, {7'd0, ew});
    cmp(tag, "dev_rd", {7'd0, dev_rd}, {7'd0, er});
    if (ew || er) begin
      cmp(tag, "dev_idx", dev_idx, m_idx);
      cmp(tag, "dev_ldn", dev_ldn, m_ldn);
    end
    if (ew) cmp(tag, "dev_wdata", dev_wdata, d);
    if (rd && !wr)
      m_rdata = (hit && m_st == 2) ? (a[0] ? local_rd(m_idx, m_ldn) : m_idx) : 8'hFF;
    if (wr && hit) begin
      if (!a[0]) begin
        case (m_st)
          0: if (d == 8'h87) m_st = 1;
          1: m_st = (d == 8'h87) ? 2 : 0;
          default: if (d == 8'hAA) m_st = 0; else m_idx = d;
        endcase
      end else if (m_st == 2 && m_idx == 8'h07) m_ldn = d;
    end
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    cmp(tag, "host_rdata", host_rdata, m_rdata);
  endtask

  task automatic iw(input logic [15:0] a, input logic [7:0] d, input string t); step(1, 0, a, d, t); endtask
  task automatic dw(input logic [15:0] a, input logic [7:0] d, input string t); step(1, 0, a | 16'h1, d, t); endtask
  task automatic rd_i(input logic [15:0] a, input string t); step(0, 1, a, 8'h00, t); endtask
  task automatic rd_d(input logic [15:0] a, input string t); step(0, 1, a | 16'h1, 8'h00, t); endtask
  task automatic idle(input string t); step(0, 0, 16'h0000, 8'h00, t); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strap_alt = 0; host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    m_st = 0; m_idx = 0; m_ldn = 0; m_rdata = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    cmp("R2", "reset host_rdata", host_rdata, 8'hFF);
    cmp("R2", "reset dev_wr", {7'd0, dev_wr}, 8'd0);

    // R6: locked behaviour
    rd_d(16'h2E, "R6");
    rd_i(16'h2E, "R6");
    iw(16'h2E, 8'h30, "R6");
    dw(16'h2E, 8'h55, "R6");
    iw(16'h2E, 8'hAA, "R6");
    rd_d(16'h2E, "R6");

    // R4: partial key cancelled
    iw(16'h2E, 8'h87, "R4");
    rd_d(16'h2E, "R4");
    iw(16'h2E, 8'h12, "R4");
    iw(16'h2E, 8'h87, "R4");
    rd_i(16'h2E, "R4");

    // R3: proper unlock; R2 reset index and device number
    iw(16'h2E, 8'h87, "R3");
    iw(16'h2E, 8'h87, "R3");
    rd_i(16'h2E, "R2");
    iw(16'h2E, 8'h07, "R7");
    rd_i(16'h2E, "R7");
    rd_d(16'h2E, "R2");
    dw(16'h2E, 8'h06, "R9");
    rd_d(16'h2E, "R9");

    // R8: identification bytes, read-only
    for (int i = 8'h20; i <= 8'h24; i++) begin
      iw(16'h2E, i[7:0], "R8");
      rd_d(16'h2E, "R8");
    end
    iw(16'h2E, 8'h20, "R8");
    dw(16'h2E, 8'hFF, "R8");
    rd_d(16'h2E, "R8");

    // R10: other local indices
    iw(16'h2E, 8'h10, "R10");
    dw(16'h2E, 8'h77, "R10");
    rd_d(16'h2E, "R10");
    iw(16'h2E, 8'h2F, "R10");
    rd_d(16'h2E, "R10");

    // R11: forwarded window, R12: hold
    iw(16'h2E, 8'h30, "R11");
    dw(16'h2E, 8'hC3, "R11");
    rd_d(16'h2E, "R11");
    iw(16'h2E, 8'hF0, "R11");
    dw(16'h2E, 8'h5A, "R11");
    rd_d(16'h2E, "R11");
    idle("R12");
    idle("R12");

    // R1: foreign base ignored
    rd_d(16'h4E, "R1");
    iw(16'h4E, 8'h07, "R1");
    dw(16'h4E, 8'h99, "R1");
    rd_i(16'h2E, "R1");

    // R5: exit key keeps index; R9 device number survives
    iw(16'h2E, 8'hAA, "R5");
    rd_i(16'h2E, "R5");
    dw(16'h2E, 8'h11, "R6");
    rd_d(16'h2E, "R6");
    iw(16'h2E, 8'h87, "R5");
    iw(16'h2E, 8'h87, "R5");
    rd_i(16'h2E, "R5");
    iw(16'h2E, 8'h07, "R9");
    rd_d(16'h2E, "R9");

    // R1: alternate strap
    idle("R1");
    strap_alt = 1;
    idle("R1");
    rd_i(16'h4E, "R1");
    rd_i(16'h2E, "R1");
    iw(16'h2E, 8'h22, "R1");
    rd_i(16'h4E, "R1");
    iw(16'h4E, 8'h22, "R1");
    rd_d(16'h4F, "R1");
    iw(16'h4E, 8'h40, "R11");
    dw(16'h4E, 8'h01, "R11");
    rd_d(16'h4E, "R11");
    idle("R1");
    strap_alt = 0;
    idle("R1");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[3] ? 16'h2E : 16'h4E;
      case (lfsr[2:0])
        3'd0: iw(b, 8'h87, "R12");
        3'd1: iw(b, (lfsr[8] ? 8'hAA : 8'h87), "R12");
        3'd2: iw(b, (lfsr[9] ? lfsr[15:8] : {3'b001, lfsr[12:8]}), "R12");
        3'd3: dw(b, lfsr[15:8], "R12");
        3'd4: rd_d(b, "R12");
        3'd5: rd_i(b, "R12");
        3'd6: idle("R12");
        default: iw(b, (lfsr[10] ? 8'h07 : 8'h30), "R12");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule